// File: doc/BRIEF.md
# Indirect Codec Control Register Port

This block is the host-facing control port of an audio codec. The host sees four byte-wide addresses: an index register, a data window onto a file of 32 indirect control registers selected by that index, a status register, and a programmed-I/O data slot. Every access moves one byte: a write is one cycle with `host_wr` high, and a read is one cycle with `host_rd` high. Read data is combinational from the current state.

The indirect file applies per-register write rules. Some slots ignore writes. One slot is read-only. One configuration slot forces a bit to zero. The mode slot keeps only its extended-addressing bit. The format slot accepts a write only under a mode-change handshake. The index carries a mode-change-enable flag. When that flag rises while auto-calibration is enabled, the read-only initialisation slot reports "calibration busy" for a preset number of polls.

A one-cycle `period_done` event from the playback engine raises the interrupt. The interrupt is cleared by any write to the status address, or by software clearing the playback flag in the alternate status slot. Each accepted format write produces a one-cycle `fmt_load` pulse, so the downstream sample engine can reconfigure itself.

Top module: `codec_regport`

## Requirements
- R1: Address 0 reads back the index register. The index resets to 0x40. A write stores bits 6:0, and bit 7 always reads as 0. Bit 6 is the mode-change-enable flag.
- R2: The indirect registers reset to these values: 0x88 in slots 2, 3, 4, 5, 18 and 19; 0x80 in slots 6 and 7; 0x08 in slot 9; 0x8A in slot 12; 0xA0 in slots 25 and 26; and 0x00 in every other slot.
- R3: Slot 12 bit 6 selects extended addressing. When it is clear, the data window uses index bits 3:0 (slots 0 to 15). When it is set, the window uses index bits 4:0 (slots 0 to 31).
- R4: Writes to slots 22, 27 and 29 are ignored. Slot 11 is read-only.
- R5: A write to slot 9 stores the byte with bit 5 forced to 0.
- R6: A write to slot 12 stores only bit 6. The other bits keep their reset pattern 0x8A.
- R7: The calibration-busy counter loads POLL_LOAD (default 1) only when both of these hold: the mode-change-enable flag goes from 0 to 1 by an index write, and slot 9 has bit 3 or bit 4 set. While the counter is nonzero, each read of slot 11 returns bit 5 set and decrements the counter. Any other read of slot 11 returns the stored value 0x00.
- R8: Any write to address 2 clears the interrupt, `irq` and status bit 0. It also clears bits 4, 5 and 6 of slot 24.
- R9: A write to slot 24 that clears bit 4 while bit 4 was set clears the interrupt. A write to slot 24 that leaves bit 4 set, or that sets it, leaves the interrupt unchanged.
- R10: A `period_done` cycle sets the interrupt, making `irq` 1 and status bit 0 equal to 1, and sets slot 24 bit 4. It wins over a clear in the same cycle.
- R11: A write to slot 8 is handled by the first rule that applies:
  - With mode-change-enable set, the whole byte is taken.
  - Otherwise, with slot 24 bit 4 set, bits 7:4 are taken and bits 3:0 keep their old value.
  - Otherwise the write is ignored.
  Each accepted write raises `fmt_load` for exactly the one cycle after the write edge, and `fmt_value` shows the new slot 8 value from that cycle on.
- R12: Writes to address 3 are ignored, and reads of address 3 return 0x00. A read of address 2 returns the interrupt in bit 0 and zeros in bits 7:1.
- R13: Every other slot stores the full written byte and reads it back unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_addr | input | 2 | Direct address: 0 index, 1 data window, 2 status, 3 programmed-I/O data |
| host_wr | input | 1 | One-cycle write strobe |
| host_rd | input | 1 | One-cycle read strobe |
| host_wdata | input | 8 | Write byte |
| host_rdata | output | 8 | Read byte, combinational from state |
| period_done | input | 1 | One-cycle playback-period event from the sample engine |
| fmt_load | output | 1 | One-cycle pulse after an accepted format write |
| fmt_value | output | 8 | Current contents of the format slot |
| irq | output | 1 | Interrupt line, equal to status bit 0 |

## Verification
The assertions assume that `host_wr` and `host_rd` are never high in the same cycle. They also assume that each strobe stands for exactly one access, so a read of slot 11 held high for several cycles would count as several polls. The bench keeps within this by driving every input on the falling edge and holding each strobe for a single cycle. The only overlap it creates on purpose is a `period_done` event in the same cycle as a status write, which tests the set-wins priority.

// File: rtl/codec_regport_pkg.sv
package codec_regport_pkg;
  localparam int BYTE_W     = 8;
  localparam int NUM_IREGS  = 32;
  localparam int IDX_W      = $clog2(NUM_IREGS);
  localparam int HOLD_W     = 7;

  localparam int SLOT_FMT   = 8;
  localparam int SLOT_CFG   = 9;
  localparam int SLOT_INIT  = 11;
  localparam int SLOT_MODE  = 12;
  localparam int SLOT_ALTST = 24;

  localparam int MCHG_BIT   = 6;
  localparam int EXT_BIT    = 6;
  localparam int BUSY_BIT   = 5;
  localparam int PLAY_BIT   = 4;

  localparam logic [7:0] CFG_ZERO_MASK = 8'h20;
  localparam logic [7:0] ALT_CLR_MASK  = 8'h70;
  localparam logic [7:0] MODE_KEEP     = 8'hBF;

  typedef enum logic [1:0] {
    A_INDEX  = 2'd0,
    A_DATA   = 2'd1,
    A_STATUS = 2'd2,
    A_PIO    = 2'd3
  } host_addr_e;

  function automatic logic [7:0] ireg_reset(input int idx);
    case (idx)
      2, 3, 4, 5, 18, 19: return 8'h88;
      6, 7:               return 8'h80;
      SLOT_CFG:           return 8'h08;
      SLOT_MODE:          return 8'h8A;
      25, 26:             return 8'hA0;
      default:            return 8'h00;
    endcase
  endfunction

  function automatic logic ireg_locked(input int idx);
    return (idx == 22) || (idx == 27) || (idx == 29) || (idx == SLOT_INIT);
  endfunction

  function automatic logic [IDX_W-1:0] eff_index(input logic [HOLD_W-1:0] idx,
                                                 input logic ext);
    return ext ? idx[IDX_W-1:0] : {1'b0, idx[IDX_W-2:0]};
  endfunction

  function automatic logic [7:0] ireg_write(input int idx, input logic [7:0] old,
                                            input logic [7:0] wd, input logic mchg,
                                            input logic play_hold);
    if (ireg_locked(idx)) return old;
    case (idx)
      SLOT_FMT:  return mchg ? wd : (play_hold ? {wd[7:4], old[3:0]} : old);
      SLOT_CFG:  return wd & ~CFG_ZERO_MASK;
      SLOT_MODE: return (old & MODE_KEEP) | (wd & ~MODE_KEEP);
      default:   return wd;
    endcase
  endfunction
endpackage

// File: rtl/codec_index_unit.sv
module codec_index_unit
  import codec_regport_pkg::*;
#(
  parameter int POLL_LOAD = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              idx_wr,
  input  logic [HOLD_W-1:0] idx_wdata,
  input  logic              cal_arm,
  input  logic              busy_rd,
  output logic [HOLD_W-1:0] index_q,
  output logic              mchg,
  output logic              busy
);
  localparam int CNT_W = (POLL_LOAD < 1) ? 1 : $clog2(POLL_LOAD + 1);
  localparam logic [CNT_W-1:0] LOAD_V = CNT_W'(POLL_LOAD);

  logic [CNT_W-1:0] cnt_q;
  logic             mchg_rise;

  assign mchg      = index_q[MCHG_BIT];
  assign mchg_rise = idx_wr & idx_wdata[MCHG_BIT] & ~index_q[MCHG_BIT];
  assign busy      = (cnt_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) index_q <= HOLD_W'(8'h40);
    else if (idx_wr) index_q <= idx_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (mchg_rise && cal_arm) cnt_q <= LOAD_V;
    else if (busy_rd && busy) cnt_q <= cnt_q - 1'b1;
  end

  assert_index_store_R1: assert property (@(posedge clk) disable iff (!rst_n)
    idx_wr |=> index_q == $past(idx_wdata));
  assert_poll_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mchg_rise && cal_arm) |=> cnt_q == LOAD_V);
  assert_poll_dec_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_rd && busy && !mchg_rise) |=> cnt_q == $past(cnt_q) - 1'b1);
  assert_poll_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!(mchg_rise && cal_arm) && !busy_rd) |=> $stable(cnt_q));
endmodule

// File: rtl/codec_ireg_file.sv
module codec_ireg_file
  import codec_regport_pkg::*;
(
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          dat_wr,
  input  logic [IDX_W-1:0]              iaddr,
  input  logic [BYTE_W-1:0]             wdata,
  input  logic                          mchg,
  input  logic                          stat_clr,
  input  logic                          period_evt,
  output logic [NUM_IREGS*BYTE_W-1:0]   regs_flat,
  output logic                          fmt_load,
  output logic                          play_drop
);
  logic [BYTE_W-1:0] regs_w [NUM_IREGS];
  logic              play_hold;
  logic              fmt_accept;

  assign play_hold  = regs_w[SLOT_ALTST][PLAY_BIT];
  assign fmt_accept = dat_wr && (iaddr == IDX_W'(SLOT_FMT)) && (mchg || play_hold);
  assign play_drop  = dat_wr && (iaddr == IDX_W'(SLOT_ALTST)) && play_hold && !wdata[PLAY_BIT];

  for (genvar g = 0; g < NUM_IREGS; g++) begin : g_slot
    logic [BYTE_W-1:0] q;
    logic [BYTE_W-1:0] nxt;
    logic              we;

    assign we = dat_wr && (iaddr == IDX_W'(g));

    always_comb begin
      nxt = q;
      if (we) nxt = ireg_write(g, q, wdata, mchg, play_hold);
      if (g == SLOT_ALTST) begin
        if (stat_clr)   nxt = nxt & ~ALT_CLR_MASK;
        if (period_evt) nxt = nxt | (8'h01 << PLAY_BIT);
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= ireg_reset(g);
      else q <= nxt;
    end

    assign regs_w[g] = q;
    assign regs_flat[g*BYTE_W +: BYTE_W] = q;

    if (ireg_locked(g)) begin : g_lock
      assert_locked_R4: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> $stable(q));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fmt_load <= 1'b0;
    else fmt_load <= fmt_accept;
  end

  assert_cfg_bit5_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_wr && iaddr == IDX_W'(SLOT_CFG)) |=> !regs_w[SLOT_CFG][5]);
  assert_mode_keep_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_wr && iaddr == IDX_W'(SLOT_MODE)) |=>
      (regs_w[SLOT_MODE] & MODE_KEEP) == $past(regs_w[SLOT_MODE] & MODE_KEEP));
  assert_fmt_ignore_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_wr && iaddr == IDX_W'(SLOT_FMT) && !mchg && !play_hold) |=>
      ($stable(regs_w[SLOT_FMT]) && !fmt_load));
  assert_fmt_nibble_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_wr && iaddr == IDX_W'(SLOT_FMT) && !mchg && play_hold) |=>
      (regs_w[SLOT_FMT][3:0] == $past(regs_w[SLOT_FMT][3:0]) && fmt_load));
  assert_alt_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_clr && !period_evt && !dat_wr) |=> (regs_w[SLOT_ALTST] & ALT_CLR_MASK) == 8'h00);
endmodule

// File: rtl/codec_irq_unit.sv
module codec_irq_unit (
  input  logic clk,
  input  logic rst_n,
  input  logic period_evt,
  input  logic stat_clr,
  input  logic play_drop,
  output logic int_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) int_q <= 1'b0;
    else if (period_evt) int_q <= 1'b1;
    else if (stat_clr || play_drop) int_q <= 1'b0;
  end

  assert_irq_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
    period_evt |=> int_q);
  assert_irq_status_clr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_clr && !period_evt) |=> !int_q);
  assert_irq_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (play_drop && !period_evt) |=> !int_q);
  assert_irq_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!period_evt && !stat_clr && !play_drop) |=> $stable(int_q));
endmodule

// File: rtl/codec_regport.sv
module codec_regport
  import codec_regport_pkg::*;
#(
  parameter int POLL_LOAD = 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  host_addr,
  input  logic        host_wr,
  input  logic        host_rd,
  input  logic [7:0]  host_wdata,
  output logic [7:0]  host_rdata,
  input  logic        period_done,
  output logic        fmt_load,
  output logic [7:0]  fmt_value,
  output logic        irq
);
  logic [HOLD_W-1:0]           index_q;
  logic                        mchg, busy, ext, cal_arm;
  logic [IDX_W-1:0]            iaddr;
  logic [NUM_IREGS*BYTE_W-1:0] regs_flat;
  logic                        idx_wr, dat_wr, stat_clr, dat_rd, busy_rd, play_drop;
  logic [BYTE_W-1:0]           slot_rd;

  assign idx_wr   = host_wr && (host_addr == A_INDEX);
  assign dat_wr   = host_wr && (host_addr == A_DATA);
  assign stat_clr = host_wr && (host_addr == A_STATUS);
  assign dat_rd   = host_rd && (host_addr == A_DATA);

  assign ext     = regs_flat[SLOT_MODE*BYTE_W + EXT_BIT];
  assign cal_arm = regs_flat[SLOT_CFG*BYTE_W + 3] | regs_flat[SLOT_CFG*BYTE_W + 4];
  assign iaddr   = eff_index(index_q, ext);
  assign busy_rd = dat_rd && (iaddr == IDX_W'(SLOT_INIT));

  codec_index_unit #(.POLL_LOAD(POLL_LOAD)) u_index (
    .clk(clk), .rst_n(rst_n), .idx_wr(idx_wr), .idx_wdata(host_wdata[HOLD_W-1:0]),
    .cal_arm(cal_arm), .busy_rd(busy_rd), .index_q(index_q), .mchg(mchg), .busy(busy)
  );

  codec_ireg_file u_file (
    .clk(clk), .rst_n(rst_n), .dat_wr(dat_wr), .iaddr(iaddr), .wdata(host_wdata),
    .mchg(mchg), .stat_clr(stat_clr), .period_evt(period_done),
    .regs_flat(regs_flat), .fmt_load(fmt_load), .play_drop(play_drop)
  );

  codec_irq_unit u_irq (
    .clk(clk), .rst_n(rst_n), .period_evt(period_done), .stat_clr(stat_clr),
    .play_drop(play_drop), .int_q(irq)
  );

  assign fmt_value = regs_flat[SLOT_FMT*BYTE_W +: BYTE_W];

  always_comb begin
    slot_rd = regs_flat[iaddr*BYTE_W +: BYTE_W];
    if (iaddr == IDX_W'(SLOT_INIT) && busy) slot_rd[BUSY_BIT] = 1'b1;
  end

  always_comb begin
    case (host_addr)
      A_INDEX:  host_rdata = {1'b0, index_q};
      A_DATA:   host_rdata = slot_rd;
      A_STATUS: host_rdata = {7'd0, irq};
      default:  host_rdata = 8'h00;
    endcase
  end

  assert_index_msb_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (host_addr == A_INDEX) |-> !host_rdata[7]);
  assert_pio_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (host_addr == A_PIO) |-> host_rdata == 8'h00);
  assert_busy_bit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_rd && busy) |-> host_rdata[BUSY_BIT]);
  assert_status_irq_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (host_addr == A_STATUS) |-> host_rdata == {7'd0, irq});
endmodule

// File: tb/codec_regport_bench.sv
`timescale 1ns/1ps
module codec_regport_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] host_addr = 2'd0;
  logic       host_wr = 1'b0, host_rd = 1'b0, period_done = 1'b0;
  logic [7:0] host_wdata = 8'h00;
  logic [7:0] host_rdata, fmt_value;
  logic       fmt_load, irq;

  int n_checks = 0;
  int n_fail = 0;
  int n_pulses = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  codec_regport u_codec_regport (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
    .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .period_done(period_done), .fmt_load(fmt_load), .fmt_value(fmt_value), .irq(irq)
  );

  always @(posedge clk) if (rst_n && fmt_load) n_pulses++;

  function automatic logic [7:0] exp_reset(input int i);
    if (i >= 2 && i <= 5) return 8'h88;
    if (i == 18 || i == 19) return 8'h88;
    if (i == 6 || i == 7) return 8'h80;
    if (i == 9) return 8'h08;
    if (i == 12) return 8'h8A;
    if (i == 25 || i == 26) return 8'hA0;
    return 8'h00;
  endfunction

  function automatic logic [7:0] pat(input int i);
    return 8'((i * 37 + 5) % 256);
  endfunction

  function automatic bit special(input int i);
    return i == 8 || i == 9 || i == 11 || i == 12 || i == 22 || i == 24 || i == 27 || i == 29;
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); host_addr = a; host_wdata = d; host_wr = 1'b1;
    @(negedge clk); host_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); host_addr = a; host_rd = 1'b1; #1 d = host_rdata;
    @(negedge clk); host_rd = 1'b0;
  endtask

  task automatic pulse_period();
    @(negedge clk); period_done = 1'b1;
    @(negedge clk); period_done = 1'b0;
  endtask

  task automatic rd_slot(input logic [7:0] idx, output logic [7:0] d);
    wr(2'd0, idx);
    rd(2'd1, d);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      finish_run();
    end
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 / R12 reset state
    rd(2'd0, v); check("R1 index reset", v, 8'h40);
    rd(2'd2, v); check("R12 status reset", v, 8'h00);
    rd(2'd3, v); check("R12 pio reset", v, 8'h00);
    check("R10 irq reset", {7'd0, irq}, 8'h00);
    check("R11 fmt_load reset", {7'd0, fmt_load}, 8'h00);

    // R2 reset values, short addressing
    for (int i = 0; i < 16; i++) begin
      rd_slot(8'h40 | 8'(i), v); check($sformatf("R2 reset slot %0d", i), v, exp_reset(i));
    end
    rd_slot(8'h5C, v); check("R3 short alias of slot 12", v, 8'h8A);

    // enable extended addressing, then remaining reset values
    wr(2'd0, 8'h4C); wr(2'd1, 8'h40);
    rd(2'd1, v); check("R6 mode set ext", v, 8'hCA);
    for (int i = 16; i < 32; i++) begin
      rd_slot(8'h40 | 8'(i), v); check($sformatf("R2 reset slot %0d", i), v, exp_reset(i));
    end

    // R13 plain slots and R4 locked slots
    for (int i = 0; i < 32; i++) begin
      wr(2'd0, 8'h40 | 8'(i));
      if (!special(i)) wr(2'd1, pat(i));
      else if (i == 11 || i == 22 || i == 27 || i == 29) wr(2'd1, 8'hFF);
    end
    for (int i = 0; i < 32; i++) begin
      rd_slot(8'h40 | 8'(i), v);
      if (!special(i)) check($sformatf("R13 slot %0d", i), v, pat(i));
      else if (i == 11 || i == 22 || i == 27 || i == 29)
        check($sformatf("R4 locked slot %0d", i), v, 8'h00);
    end

    // R5
    wr(2'd0, 8'h49); wr(2'd1, 8'hFF);
    rd(2'd1, v); check("R5 cfg bit5 forced 0", v, 8'hDF);
    wr(2'd1, 8'h20);
    rd(2'd1, v); check("R5 cfg only bit5", v, 8'h00);

    // R6 / R3 addressing width
    wr(2'd0, 8'h4C); wr(2'd1, 8'h00);
    rd(2'd1, v); check("R6 mode cleared keeps 0x8A", v, 8'h8A);
    wr(2'd0, 8'h53); wr(2'd1, 8'h5A);
    rd(2'd1, v); check("R3 short index 0x13 hits slot 3", v, 8'h5A);
    wr(2'd0, 8'h4C); wr(2'd1, 8'hFF);
    rd(2'd1, v); check("R6 mode stores bit6 only", v, 8'hCA);
    rd_slot(8'h53, v); check("R3 ext index 0x13 hits slot 19", v, pat(19));
    rd_slot(8'h43, v); check("R3 ext slot 3", v, 8'h5A);

    // R7 calibration busy polling
    wr(2'd0, 8'h0B); wr(2'd0, 8'h4B);
    rd(2'd1, v); check("R7 no arm with cfg bits clear", v, 8'h00);
    wr(2'd0, 8'h49); wr(2'd1, 8'h08);
    wr(2'd0, 8'h0B); wr(2'd0, 8'h4B);
    rd(2'd1, v); check("R7 busy after rise bit3", v, 8'h20);
    rd(2'd1, v); check("R7 busy expired", v, 8'h00);
    wr(2'd0, 8'h4B);
    rd(2'd1, v); check("R7 no reload while held", v, 8'h00);
    wr(2'd0, 8'h49); wr(2'd1, 8'h10);
    wr(2'd0, 8'h0B); wr(2'd0, 8'h4B);
    rd(2'd1, v); check("R7 busy after rise bit4", v, 8'h20);
    rd(2'd1, v); check("R7 busy expired bit4", v, 8'h00);

    // R10 / R8 / R9 interrupt
    pulse_period();
    check("R10 irq set", {7'd0, irq}, 8'h01);
    rd(2'd2, v); check("R12 status int bit", v, 8'h01);
    rd_slot(8'h58, v); check("R10 slot24 flag", v, 8'h10);
    wr(2'd2, 8'h00);
    check("R8 irq cleared", {7'd0, irq}, 8'h00);
    rd(2'd2, v); check("R8 status cleared", v, 8'h00);
    rd(2'd1, v); check("R8 slot24 cleared", v, 8'h00);
    wr(2'd1, 8'h6F);
    check("R9 writing flag does not raise", {7'd0, irq}, 8'h00);
    pulse_period();
    rd(2'd1, v); check("R10 slot24 or flag", v, 8'h7F);
    wr(2'd2, 8'hFF);
    rd(2'd1, v); check("R8 slot24 bits 6:4 cleared", v, 8'h0F);
    check("R8 irq low", {7'd0, irq}, 8'h00);
    pulse_period();
    wr(2'd1, 8'h10);
    check("R9 flag kept irq holds", {7'd0, irq}, 8'h01);
    wr(2'd1, 8'h00);
    check("R9 flag dropped clears irq", {7'd0, irq}, 8'h00);
    rd(2'd2, v); check("R9 status cleared", v, 8'h00);
    @(negedge clk); host_addr = 2'd2; host_wr = 1'b1; period_done = 1'b1;
    @(negedge clk); host_wr = 1'b0; period_done = 1'b0;
    check("R10 set wins over clear", {7'd0, irq}, 8'h01);
    rd(2'd1, v); check("R10 slot24 set wins", v, 8'h10);
    wr(2'd2, 8'h00);
    rd(2'd1, v); check("R8 final clear", v, 8'h00);

    // R11 format slot
    wr(2'd0, 8'h08); wr(2'd1, 8'hAB);
    check("R11 ignored no pulse", {7'd0, fmt_load}, 8'h00);
    rd(2'd1, v); check("R11 ignored value", v, 8'h00);
    wr(2'd0, 8'h48); wr(2'd1, 8'h3C);
    check("R11 pulse with mode change", {7'd0, fmt_load}, 8'h01);
    @(negedge clk);
    check("R11 pulse one cycle", {7'd0, fmt_load}, 8'h00);
    check("R11 fmt_value full", fmt_value, 8'h3C);
    wr(2'd0, 8'h58); wr(2'd1, 8'h10);
    check("R9 setting flag leaves irq low", {7'd0, irq}, 8'h00);
    wr(2'd0, 8'h08); wr(2'd1, 8'hF5);
    check("R11 pulse via flag", {7'd0, fmt_load}, 8'h01);
    check("R11 upper nibble only", fmt_value, 8'hFC);
    rd(2'd1, v); check("R11 readback", v, 8'hFC);
    check("R11 pulse count", 8'(n_pulses), 8'd2);

    // R12 PIO slot
    wr(2'd3, 8'hFF);
    rd(2'd3, v); check("R12 pio ignored", v, 8'h00);
    rd(2'd0, v); check("R12 index untouched", v, 8'h08);
    wr(2'd0, 8'hFF);
    rd(2'd0, v); check("R1 bit7 dropped", v, 8'h7F);

    done = 1'b1;
    finish_run();
  end
endmodule